// File: doc/BRIEF.md
# Indirect Register Access Port

This block is the host-facing front end of a network controller's register file. The host sees a 32-byte I/O window and reaches the controller's indexed registers indirectly. It first writes a register index into a pointer port. It then reads or writes the selected register through one of two data ports. One data port serves the control/status bank and the other serves the bus-configuration bank. The low 16 bytes of the window expose a read-only station-address area. A read of a dedicated reset port launches a one-cycle soft reset.

The window works in one of two access-width modes. After any reset the block expects 16-bit word accesses, with byte reads in the address area. A single 32-bit write to the control data port moves it into 32-bit mode. In 32-bit mode every port is an aligned double word, and the pointer and reset ports sit at different offsets. The mode stays set until the next reset. An access whose size or alignment does not fit the current mode is dropped. The reset port only fires when it is read at the width of the current mode.

Each access takes one cycle, with `io_valid` high. Read data is combinational from the current state and is valid in the same cycle. State changes land at the clock edge that ends the access.

Top module: `regport_front`

## Requirements
- R1: After hard reset the block is in 16-bit mode, the register pointer is 0, and `soft_rst_o` is low.
- R2: In 16-bit mode, byte reads (size 0) of offsets 0x00–0x0F return station byte N, which is `STATION_ID[8N+7:8N]` for N below 6 and 0x00 above that, in `io_rdata[7:0]` with the upper bits zero. Writes to this area change nothing.
- R3: In 16-bit mode, word accesses (size 1) reach three ports. Offset 0x10 is the control register selected by the pointer. Offset 0x12 is the pointer. Offset 0x16 is the bus-configuration register selected by the pointer. Read data is zero-extended.
- R4: In 16-bit mode, a double-word write (size 2) to offset 0x10 switches the block to 32-bit mode. The same write stores `io_wdata[15:0]` into the selected control register.
- R5: In 32-bit mode, only aligned double words are accepted. Offset 0x10 is the control data port, 0x14 is the pointer, and 0x1C is the bus-configuration data port. Offsets 0x00/0x04/0x08/0x0C return four station bytes packed little-endian.
- R6: An access whose size or alignment does not match the current mode is ignored when it is a write. It returns 0xFFFFFFFF when it is a read.
- R7: The pointer holds a 7-bit index taken from `io_wdata[6:0]`, and it reads back zero-extended. An index at or above the bank depth (8) reads as 0, and writes to it are dropped.
- R8: A word read of 0x14 in 16-bit mode, or a double-word read of 0x18 in 32-bit mode, returns 0. It drives `soft_rst_o` high for exactly the next cycle. At the end of that cycle the mode returns to 16-bit and the pointer to 0. Register contents are kept.
- R9: A double-word read of 0x18 in 16-bit mode returns 0xFFFFFFFF and does not raise `soft_rst_o`.
- R10: During the cycle in which `soft_rst_o` is high, the reset wins over a mode-entry or pointer write in that same cycle. A register-bank write in that cycle still lands, using the pointer value held before the reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hard reset |
| io_valid | input | 1 | An access is presented this cycle |
| io_write | input | 1 | 1 = write, 0 = read |
| io_addr | input | 5 | Byte offset in the I/O window |
| io_size | input | 2 | Access size: 0 byte, 1 word, 2 double word |
| io_wdata | input | 32 | Write data, right-justified |
| io_rdata | output | 32 | Read data, right-justified, valid in the access cycle |
| soft_rst_o | output | 1 | One-cycle soft reset pulse |

## Verification
A soft reset and a host access can fall in the same cycle. The pulse is high during the cycle right after the reset-port read, and the host is free to issue its next access in exactly that cycle. The bench provokes this case by following a reset read at once with either a double-word write to 0x10 or a pointer write. It judges the outcome through the ports afterwards. A double-word read must return all-ones, which proves the block is still in 16-bit mode, and the pointer must read back as 0. Meanwhile the control register selected before the reset must hold the data written during the pulse.

// File: rtl/regport_front.sv
module regport_front #(
  parameter int          NCSR       = 8,
  parameter int          NBCR       = 8,
  parameter int          DATA_W     = 16,
  parameter int          RAP_W      = 7,
  parameter logic [47:0] STATION_ID = 48'h6655_4433_2211
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        io_valid,
  input  logic        io_write,
  input  logic [4:0]  io_addr,
  input  logic [1:0]  io_size,
  input  logic [31:0] io_wdata,
  output logic [31:0] io_rdata,
  output logic        soft_rst_o
);

  localparam int           CSR_IW  = $clog2(NCSR);
  localparam int           BCR_IW  = $clog2(NBCR);
  localparam logic [127:0] ROM_IMG = {80'd0, STATION_ID};
  localparam logic [1:0]   SZ_B = 2'd0, SZ_W = 2'd1, SZ_D = 2'd2;

  logic              mode_q;
  logic [RAP_W-1:0]  rap_q;
  logic              soft_q;
  logic [DATA_W-1:0] csr_q [NCSR];
  logic [DATA_W-1:0] bcr_q [NBCR];

  logic rom_hit, csr_hit, rap_hit, rst_hit, bcr_hit, enter32;

  wire is_b = io_size == SZ_B;
  wire is_w = io_size == SZ_W;
  wire is_d = io_size == SZ_D;
  wire wr   = io_valid && io_write;

  always_comb begin
    rom_hit = 1'b0;
    csr_hit = 1'b0;
    rap_hit = 1'b0;
    rst_hit = 1'b0;
    bcr_hit = 1'b0;
    enter32 = 1'b0;
    if (!mode_q) begin
      rom_hit = is_b && !io_addr[4];
      csr_hit = is_w && io_addr == 5'h10;
      rap_hit = is_w && io_addr == 5'h12;
      rst_hit = is_w && io_addr == 5'h14;
      bcr_hit = is_w && io_addr == 5'h16;
      enter32 = is_d && io_addr == 5'h10 && io_write;
    end else if (is_d && io_addr[1:0] == 2'b00) begin
      rom_hit = !io_addr[4];
      csr_hit = io_addr == 5'h10;
      rap_hit = io_addr == 5'h14;
      rst_hit = io_addr == 5'h18;
      bcr_hit = io_addr == 5'h1C;
    end
  end

  wire               csr_ok  = rap_q < RAP_W'(NCSR);
  wire               bcr_ok  = rap_q < RAP_W'(NBCR);
  wire [CSR_IW-1:0]  csr_sel = rap_q[CSR_IW-1:0];
  wire [BCR_IW-1:0]  bcr_sel = rap_q[BCR_IW-1:0];
  wire               rd_rst  = io_valid && !io_write && rst_hit && !soft_q;

  always_comb begin
    io_rdata = '1;
    if (rom_hit)
      io_rdata = mode_q ? ROM_IMG[{io_addr[3:2], 5'd0} +: 32]
                        : {24'd0, ROM_IMG[{io_addr[3:0], 3'd0} +: 8]};
    else if (csr_hit)
      io_rdata = csr_ok ? 32'(csr_q[csr_sel]) : 32'd0;
    else if (bcr_hit)
      io_rdata = bcr_ok ? 32'(bcr_q[bcr_sel]) : 32'd0;
    else if (rap_hit)
      io_rdata = 32'(rap_q);
    else if (rst_hit)
      io_rdata = 32'd0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= 1'b0;
      rap_q  <= '0;
      soft_q <= 1'b0;
    end else begin
      soft_q <= rd_rst;
      if (soft_q) begin
        mode_q <= 1'b0;
        rap_q  <= '0;
      end else begin
        if (wr && enter32) mode_q <= 1'b1;
        if (wr && rap_hit) rap_q  <= io_wdata[RAP_W-1:0];
      end
    end
  end

  for (genvar i = 0; i < NCSR; i++) begin : g_csr
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        csr_q[i] <= '0;
      else if (wr && (csr_hit || enter32) && csr_ok && csr_sel == CSR_IW'(i))
        csr_q[i] <= io_wdata[DATA_W-1:0];
    end
  end

  for (genvar i = 0; i < NBCR; i++) begin : g_bcr
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        bcr_q[i] <= '0;
      else if (wr && bcr_hit && bcr_ok && bcr_sel == BCR_IW'(i))
        bcr_q[i] <= io_wdata[DATA_W-1:0];
    end
  end

  assign soft_rst_o = soft_q;

endmodule

// File: rtl/regport_front_chk.sv
module regport_front_chk #(
  parameter int RAP_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             io_valid,
  input logic             io_write,
  input logic [4:0]       io_addr,
  input logic [1:0]       io_size,
  input logic [31:0]      io_rdata,
  input logic             soft_rst_o,
  input logic             mode32,
  input logic [RAP_W-1:0] rap
);

  // R8
  pulse_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst_o |=> !soft_rst_o);

  // R8
  soft_clears_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst_o |=> (!mode32 && rap == '0));

  // R9
  wrong_width_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_valid && !io_write && !mode32 && io_size == 2'd2 && io_addr == 5'h18 && !soft_rst_o)
      |=> !soft_rst_o);

  // R6
  dword_read_in_word_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_valid && !io_write && !mode32 && io_size == 2'd2) |-> io_rdata == 32'hFFFF_FFFF);

  // R4
  enter_wide_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_valid && io_write && !mode32 && io_size == 2'd2 && io_addr == 5'h10 && !soft_rst_o)
      |=> mode32);

  // R6
  narrow_write_in_wide_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_valid && io_write && mode32 && io_size != 2'd2 && !soft_rst_o) |=> $stable(rap));

  // R10
  reset_beats_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (soft_rst_o && io_valid && io_write) |=> !mode32);

endmodule

bind regport_front regport_front_chk #(.RAP_W(RAP_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .io_valid   (io_valid),
  .io_write   (io_write),
  .io_addr    (io_addr),
  .io_size    (io_size),
  .io_rdata   (io_rdata),
  .soft_rst_o (soft_rst_o),
  .mode32     (mode_q),
  .rap        (rap_q)
);

// File: tb/regport_front_bench.sv
module regport_front_bench;

  localparam int CLK_T = 10;
  localparam int NV    = 38;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        io_valid = 1'b0;
  logic        io_write = 1'b0;
  logic [4:0]  io_addr = '0;
  logic [1:0]  io_size = '0;
  logic [31:0] io_wdata = '0;
  logic [31:0] io_rdata;
  logic        soft_rst_o;

  int checks = 0;
  int errs   = 0;
  bit done   = 1'b0;

  always #(CLK_T/2) clk = ~clk;

  regport_front u_regport_front (
    .clk(clk), .rst_n(rst_n), .io_valid(io_valid), .io_write(io_write),
    .io_addr(io_addr), .io_size(io_size), .io_wdata(io_wdata),
    .io_rdata(io_rdata), .soft_rst_o(soft_rst_o)
  );

  // {req[3:0], wr, size[1:0], addr[4:0], wdata[31:0], expected[31:0]}
  localparam logic [75:0] VEC [NV] = '{
    {4'd2,  1'b0, 2'd0, 5'h00, 32'h0,         32'h0000_0011}, // R2
    {4'd2,  1'b0, 2'd0, 5'h05, 32'h0,         32'h0000_0066}, // R2
    {4'd2,  1'b0, 2'd0, 5'h09, 32'h0,         32'h0000_0000}, // R2
    {4'd2,  1'b1, 2'd0, 5'h01, 32'h0000_00AA, 32'h0},         // R2 write ignored
    {4'd2,  1'b0, 2'd0, 5'h01, 32'h0,         32'h0000_0022}, // R2
    {4'd1,  1'b0, 2'd1, 5'h12, 32'h0,         32'h0000_0000}, // R1
    {4'd3,  1'b1, 2'd1, 5'h12, 32'h0000_0003, 32'h0},         // R3
    {4'd3,  1'b1, 2'd1, 5'h10, 32'h0000_1234, 32'h0},         // R3
    {4'd3,  1'b0, 2'd1, 5'h10, 32'h0,         32'h0000_1234}, // R3
    {4'd3,  1'b1, 2'd1, 5'h16, 32'h0000_BEEF, 32'h0},         // R3
    {4'd3,  1'b0, 2'd1, 5'h16, 32'h0,         32'h0000_BEEF}, // R3
    {4'd7,  1'b1, 2'd1, 5'h12, 32'h0000_FF85, 32'h0},         // R7
    {4'd7,  1'b0, 2'd1, 5'h12, 32'h0,         32'h0000_0005}, // R7
    {4'd3,  1'b1, 2'd1, 5'h10, 32'h0000_5555, 32'h0},         // R3
    {4'd3,  1'b1, 2'd1, 5'h12, 32'h0000_0003, 32'h0},         // R3
    {4'd3,  1'b0, 2'd1, 5'h10, 32'h0,         32'h0000_1234}, // R3
    {4'd7,  1'b1, 2'd1, 5'h12, 32'h0000_0040, 32'h0},         // R7
    {4'd7,  1'b1, 2'd1, 5'h10, 32'h0000_7777, 32'h0},         // R7
    {4'd7,  1'b0, 2'd1, 5'h10, 32'h0,         32'h0000_0000}, // R7
    {4'd6,  1'b0, 2'd2, 5'h10, 32'h0,         32'hFFFF_FFFF}, // R6
    {4'd6,  1'b0, 2'd1, 5'h11, 32'h0,         32'hFFFF_FFFF}, // R6
    {4'd6,  1'b0, 2'd0, 5'h10, 32'h0,         32'hFFFF_FFFF}, // R6
    {4'd6,  1'b1, 2'd1, 5'h13, 32'h0000_0001, 32'h0},         // R6
    {4'd6,  1'b0, 2'd1, 5'h12, 32'h0,         32'h0000_0040}, // R6
    {4'd4,  1'b1, 2'd1, 5'h12, 32'h0000_0002, 32'h0},         // R4
    {4'd4,  1'b1, 2'd2, 5'h10, 32'hABCD_9876, 32'h0},         // R4
    {4'd6,  1'b0, 2'd1, 5'h10, 32'h0,         32'hFFFF_FFFF}, // R6
    {4'd4,  1'b0, 2'd2, 5'h10, 32'h0,         32'h0000_9876}, // R4
    {4'd5,  1'b0, 2'd2, 5'h14, 32'h0,         32'h0000_0002}, // R5
    {4'd5,  1'b0, 2'd2, 5'h00, 32'h0,         32'h4433_2211}, // R5
    {4'd5,  1'b0, 2'd2, 5'h04, 32'h0,         32'h0000_6655}, // R5
    {4'd5,  1'b1, 2'd2, 5'h14, 32'h0000_0003, 32'h0},         // R5
    {4'd5,  1'b0, 2'd2, 5'h10, 32'h0,         32'h0000_1234}, // R5
    {4'd5,  1'b1, 2'd2, 5'h1C, 32'h0000_CAFE, 32'h0},         // R5
    {4'd5,  1'b0, 2'd2, 5'h1C, 32'h0,         32'h0000_CAFE}, // R5
    {4'd6,  1'b0, 2'd0, 5'h00, 32'h0,         32'hFFFF_FFFF}, // R6
    {4'd6,  1'b1, 2'd2, 5'h12, 32'h0000_0007, 32'h0},         // R6
    {4'd6,  1'b0, 2'd2, 5'h14, 32'h0,         32'h0000_0003}  // R6
  };

  task automatic acc(input logic w, input logic [1:0] s, input logic [4:0] a,
                     input logic [31:0] d, output logic [31:0] r);
    @(negedge clk);
    io_valid = 1'b1; io_write = w; io_size = s; io_addr = a; io_wdata = d;
    #1 r = io_rdata;
    @(posedge clk);
    #1 io_valid = 1'b0; io_write = 1'b0;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  endtask

  initial begin
    #(CLK_T * 100000);
    checks++; errs++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [31:0] r;
    logic [75:0] v;
    repeat (3) @(negedge clk);
    chk("R1 soft_rst_o in reset", 32'(soft_rst_o), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 soft_rst_o after reset", 32'(soft_rst_o), 32'd0);

    for (int i = 0; i < NV; i++) begin
      v = VEC[i];
      acc(v[71], v[70:69], v[68:64], v[63:32], r);
      if (!v[71]) chk($sformatf("R%0d vector %0d", v[75:72], i), r, v[31:0]);
    end

    // R8: 32-bit reset read
    acc(1'b0, 2'd2, 5'h18, 32'h0, r);
    chk("R8 reset port data", r, 32'd0);
    chk("R8 pulse high", 32'(soft_rst_o), 32'd1);
    @(posedge clk); #1;
    chk("R8 pulse one cycle", 32'(soft_rst_o), 32'd0);
    acc(1'b0, 2'd1, 5'h12, 32'h0, r);
    chk("R8 pointer cleared, word mode", r, 32'd0);
    acc(1'b1, 2'd1, 5'h12, 32'h3, r);
    acc(1'b0, 2'd1, 5'h10, 32'h0, r);
    chk("R8 register kept", r, 32'h0000_1234);

    // R9: wrong-width reset read
    acc(1'b0, 2'd2, 5'h18, 32'h0, r);
    chk("R9 data", r, 32'hFFFF_FFFF);
    chk("R9 no pulse", 32'(soft_rst_o), 32'd0);
    @(posedge clk); #1;
    chk("R9 still no pulse", 32'(soft_rst_o), 32'd0);
    acc(1'b0, 2'd1, 5'h12, 32'h0, r);
    chk("R9 pointer kept", r, 32'd3);

    // R8: 16-bit reset read
    acc(1'b0, 2'd1, 5'h14, 32'h0, r);
    chk("R8 word reset data", r, 32'd0);
    chk("R8 word reset pulse", 32'(soft_rst_o), 32'd1);
    @(posedge clk); #1;

    // R10: mode entry and bank write during the pulse
    acc(1'b1, 2'd1, 5'h12, 32'h2, r);
    acc(1'b0, 2'd1, 5'h14, 32'h0, r);
    acc(1'b1, 2'd2, 5'h10, 32'h0000_4321, r);
    acc(1'b0, 2'd2, 5'h10, 32'h0, r);
    chk("R10 mode stays 16-bit", r, 32'hFFFF_FFFF);
    acc(1'b0, 2'd1, 5'h12, 32'h0, r);
    chk("R10 pointer cleared", r, 32'd0);
    acc(1'b1, 2'd1, 5'h12, 32'h2, r);
    acc(1'b0, 2'd1, 5'h10, 32'h0, r);
    chk("R10 bank write landed", r, 32'h0000_4321);

    // R10: pointer write during the pulse
    acc(1'b0, 2'd1, 5'h14, 32'h0, r);
    acc(1'b1, 2'd1, 5'h12, 32'h5, r);
    acc(1'b0, 2'd1, 5'h12, 32'h0, r);
    chk("R10 pointer write dropped", r, 32'd0);

    finish_run();
  end

endmodule